// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

A processor proves that its software is still running by giving a falling edge on the `strobe` input often enough. An 8-bit configuration register picks the allowed gap between two falling edges: 250, 500 or 1000 ms. It can also switch the watchdog off. If the gap runs out with no falling edge, the block raises `rst_req` for a fixed 250 ms. A separate reset controller uses that request to drive the shared reset line.

Time is counted in pulses of `ms_tick`. The parameter `TICKS_PER_MS` sets how many tick pulses make one millisecond. The countdown is frozen at its full period while the reset controller reports reset as active (`rst_busy`). It is also frozen while the block's own request is high. Timing starts from the full period once both are low. The strobe is asynchronous and passes through a two-flop synchronizer before its falling edge is detected. Writing the register restarts timing with the newly written period.

Top module: `wdog_reset_timer`

## Requirements
- R1: Register bits 1:0 hold the timeout select, and a write stores `cfg_wdata[1:0]` there. Bits 7:2 of `cfg_rdata` are always 0, whatever was written to them.
- R2: After `rst_n` the timeout select reads 2'b11, so `cfg_rdata` = 8'h03, and `rst_req` is 0.
- R3: Timeout select 2'b01 gives 250 ms, 2'b10 gives 500 ms and 2'b11 gives 1000 ms. Each is measured as ms × `TICKS_PER_MS` tick pulses from the last load. 2'b00 disables the watchdog, and no request is ever raised.
- R4: The countdown is held at its full period while `rst_busy` or `rst_req` is high. `rst_req` rises exactly one full period after both have gone low, and never while `rst_busy` is high.
- R5: A falling edge of `strobe` reloads the full period. The reload takes effect on the third rising clock edge after `strobe` is first sampled low. A rising edge of `strobe` has no effect.
- R6: On expiry, `rst_req` is high for exactly 250 ms of ticks. The length does not depend on the timeout select or on register writes made during the pulse.
- R7: A register write reloads the countdown with the period written. Writing 2'b00 cancels a countdown that is already running.
- R8: The countdown and the pulse advance only on `ms_tick` pulses. While `ms_tick` is low, no time passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | Time-base pulse; `TICKS_PER_MS` pulses make one millisecond |
| strobe | input | 1 | Asynchronous service input; falling edges restart timing |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data; bits 1:0 are the timeout select |
| rst_busy | input | 1 | High while the reset controller holds reset active |
| cfg_rdata | output | 8 | Register contents, bits 7:2 zero |
| rst_req | output | 1 | Reset request pulse |

## Verification
The countdown is started in every way it can start: release of `rst_busy`, the end of its own pulse, a register write, and a strobe falling edge. In each case the edges to `rst_req` are counted exactly, so a wrong load point or an off-by-one shows up as a difference of a cycle or more. Random strobe trains, with gaps just under the selected period for each random timeout select, separate a watchdog that is serviced correctly from one that expires too early. A final unserviced edge then shows whether the 500 and 1000 ms periods are truly distinct. Directed cases cover the remaining behaviour:
- a rising-only strobe must not reload the countdown;
- writing 2'b00 must cancel a countdown close to expiry;
- holding `ms_tick` low must stop all progress;
- a write during the pulse must leave the pulse length alone.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        TD_OFF   = 2'b00,
        TD_SHORT = 2'b01,
        TD_MID   = 2'b10,
        TD_LONG  = 2'b11
    } td_e;

    // Period in milliseconds for a timeout select; 0 means disabled.
    function automatic int unsigned period_ms(input logic [1:0] td, input int unsigned base);
        case (td)
            TD_SHORT: return base;
            TD_MID:   return base * 2;
            TD_LONG:  return base * 4;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [1:0]       td_q,
    output logic [1:0]       td_d,
    output logic [REG_W-1:0] rdata
);
    localparam int unsigned PAD_W = REG_W - 2;

    typedef struct packed {
        logic [1:0] td;
    } cfg_s;

    cfg_s st_d, st_q;
    logic unused_hi;

    assign unused_hi = ^wdata[REG_W-1:2];

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.td = wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.td <= TD_LONG;
        end else begin
            st_q <= st_d;
        end
    end

    assign td_q  = st_q.td;
    assign td_d  = st_d.td;
    assign rdata = {{PAD_W{1'b0}}, st_q.td};

    // R1: a write shows up on the read port on the next cycle, upper bits zero
    p_reg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == {{PAD_W{1'b0}}, $past(wdata[1:0])}));

endmodule

// File: rtl/wdog_strobe_sync.sv
module wdog_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], strobe};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall = st_q.last & ~st_q.chain[STAGES-1];

    // R5: an edge is reported for one cycle only
    p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/wdog_tick_div.sv
module wdog_tick_div #(
    parameter int unsigned TICKS_PER_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic step
);
    localparam int unsigned PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_MS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } div_s;

    div_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (clear) begin
            st_d.pre = '0;
        end else if (tick) begin
            if (st_q.pre == LAST) begin
                st_d.pre = '0;
                step     = 1'b1;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 1,
    parameter int unsigned BASE_MS      = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [1:0] td_sel,
    output logic       expire
);
    localparam int unsigned CNT_W = $clog2(BASE_MS * 4 + 1);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } cnt_s;

    cnt_s st_d, st_q;
    logic step;

    wdog_tick_div #(.TICKS_PER_MS(TICKS_PER_MS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .tick  (tick),
        .step  (step)
    );

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.left = CNT_W'(period_ms(td_sel, BASE_MS));
        end else if (step && (st_q.left != '0)) begin
            if (st_q.left == CNT_W'(1)) begin
                expire = 1'b1;
            end
            st_d.left = st_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.left <= CNT_W'(period_ms(TD_LONG, BASE_MS));
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned TICKS_PER_MS = 1,
    parameter int unsigned PULSE_MS     = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic req
);
    localparam int unsigned PW = $clog2(PULSE_MS + 1);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] left;
    } pulse_s;

    pulse_s st_d, st_q;
    logic   step;
    logic   div_clear;

    assign div_clear = start | ~st_q.active;

    wdog_tick_div #(.TICKS_PER_MS(TICKS_PER_MS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (div_clear),
        .tick  (tick),
        .step  (step)
    );

    always_comb begin
        st_d = st_q;
        if (start && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.left   = PW'(PULSE_MS);
        end else if (st_q.active && step) begin
            if (st_q.left == PW'(1)) begin
                st_d.active = 1'b0;
                st_d.left   = '0;
            end else begin
                st_d.left = st_q.left - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.active;

    // R6: a running pulse is never restarted by a new expiry
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> !start);

endmodule

// File: rtl/wdog_reset_timer.sv
module wdog_reset_timer
    import wdog_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 1,
    parameter int unsigned BASE_MS      = 250,
    parameter int unsigned PULSE_MS     = 250,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned REG_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             strobe,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             rst_busy,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             rst_req
);
    logic [1:0] td_q;
    logic [1:0] td_d;
    logic       fall;
    logic       expire;
    logic       load;

    wdog_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .td_q  (td_q),
        .td_d  (td_d),
        .rdata (cfg_rdata)
    );

    wdog_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .fall   (fall)
    );

    // Hold or restart the countdown: reset active, own pulse, service, write.
    assign load = rst_busy | rst_req | fall | cfg_we;

    wdog_countdown #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .BASE_MS      (BASE_MS)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ms_tick),
        .load   (load),
        .td_sel (td_d),
        .expire (expire)
    );

    wdog_pulse #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .PULSE_MS     (PULSE_MS)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .start (expire),
        .req   (rst_req)
    );

    // R6: every expiry is followed by a request
    p_req_after_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> rst_req);

    // R3: a disabled watchdog never expires
    p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((td_q == TD_OFF) && !cfg_we) |-> !expire);

    // R4: a request never starts while the reset controller is busy
    p_no_rise_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> !$past(rst_busy));

    // R4: the countdown is frozen while the request is high
    p_held_during_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !expire);

    // R5: a detected edge comes from strobe having been low
    p_fall_from_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !$past(strobe, 2));

endmodule

// File: tb/wdog_reset_timer_test.sv
module wdog_reset_timer_test;
    localparam int unsigned T  = 2;
    localparam int          PW = 250 * T;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b1;
    logic       strobe = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       rst_busy = 1'b1;
    logic [7:0] cfg_rdata;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    wdog_reset_timer #(.TICKS_PER_MS(T)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .strobe    (strobe),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rst_busy  (rst_busy),
        .cfg_rdata (cfg_rdata),
        .rst_req   (rst_req)
    );

    always #10 clk = ~clk;

    function automatic int exp_cycles(input logic [1:0] td);
        case (td)
            2'b01:   return 250 * T;
            2'b10:   return 500 * T;
            2'b11:   return 1000 * T;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts rising edges until rst_req equals lvl (sampled at the negedge).
    task automatic wait_level(input logic lvl, input int limit, input int rel_at, output int n);
        bit done;
        done = 1'b0;
        n = 0;
        while (!done) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == rel_at) strobe = 1'b1;
            if (rst_req == lvl) done = 1'b1;
            else if (n >= limit) begin
                n = -1;
                done = 1'b1;
            end
        end
    endtask

    task automatic quiet(input int cycles, output int bad);
        bad = 0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_req) bad++;
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..R8 run): actual %0d cycles expected completion", 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int bad;
        logic [1:0] td;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk("R2 rst_req after reset", int'(rst_req), 0);
        chk("R2 register after reset", int'(cfg_rdata), 8'h03);

        // R4: held while the reset controller is busy
        quiet(3000, bad);
        chk("R4 no request while busy", bad, 0);
        rst_busy = 1'b0;
        wait_level(1'b1, 5000, -1, n);
        chk("R3 R4 default 1000 ms from busy release", n, exp_cycles(2'b11));

        // R6: pulse length, R4: restart after own pulse
        wait_level(1'b0, 2000, -1, n);
        chk("R6 pulse length", n, PW);
        wait_level(1'b1, 5000, -1, n);
        chk("R4 full period after own pulse", n, exp_cycles(2'b11));
        wait_level(1'b0, 2000, -1, n);
        chk("R6 pulse length second", n, PW);

        // R1: upper bits ignored; R7: write reloads with new period
        do_write(8'hFD);
        chk("R1 upper bits read zero", int'(cfg_rdata), 8'h01);
        wait_level(1'b1, 5000, -1, n);
        chk("R7 R3 250 ms after write", n, exp_cycles(2'b01));

        // R6: a write in the middle of the pulse does not change its length
        repeat (99) @(negedge clk);
        do_write(8'h02);
        chk("R1 select stored", int'(cfg_rdata), 8'h02);
        wait_level(1'b0, 2000, -1, n);
        chk("R6 pulse unchanged by write", n, PW - 100);
        wait_level(1'b1, 5000, -1, n);
        chk("R3 500 ms period", n, exp_cycles(2'b10));
        wait_level(1'b0, 2000, -1, n);
        chk("R6 pulse with 500 ms select", n, PW);

        // R5: a rising strobe edge is ignored
        strobe = 1'b0;
        repeat (10) @(negedge clk);
        do_write(8'h01);
        wait_level(1'b1, 5000, 100, n);
        chk("R5 rising edge ignored", n, exp_cycles(2'b01));
        wait_level(1'b0, 2000, -1, n);

        // R7: writing 00 cancels a running countdown
        do_write(8'h01);
        repeat (400) @(negedge clk);
        do_write(8'h00);
        chk("R1 select reads 00", int'(cfg_rdata), 8'h00);
        quiet(3000, bad);
        chk("R7 R3 disabled stays quiet", bad, 0);

        // R8: no time passes without ticks
        do_write(8'h01);
        ms_tick = 1'b0;
        quiet(2000, bad);
        chk("R8 frozen without ticks", bad, 0);
        ms_tick = 1'b1;
        wait_level(1'b1, 5000, -1, n);
        chk("R8 full period once ticks resume", n, exp_cycles(2'b01));
        wait_level(1'b0, 2000, -1, n);
        chk("R8 R6 pulse after resume", n, PW);

        // R5: random service trains, then one unserviced edge
        for (int r = 0; r < 6; r++) begin
            int p;
            td = 2'(1 + ($urandom % 3));
            p  = exp_cycles(td);
            do_write({6'b0, td});
            bad = 0;
            for (int k = 0; k < 5; k++) begin
                int gap;
                gap = 8 + int'($urandom % 32'(p - 9));
                strobe = 1'b0;
                for (int c = 0; c < gap; c++) begin
                    @(posedge clk);
                    @(negedge clk);
                    if (c == 2) strobe = 1'b1;
                    if (rst_req) bad++;
                end
            end
            chk("R5 serviced watchdog stays quiet", bad, 0);
            strobe = 1'b0;
            wait_level(1'b1, p + 10, 3, n);
            chk("R5 R3 expiry after last strobe edge", n, p + 3);
            wait_level(1'b0, 2000, -1, n);
            chk("R6 pulse after random train", n, PW);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule